// File: doc/BRIEF.md
# PCM Word Burst Serializer

This block turns 8-bit PCM code words into short serial bursts. A sampling converter delivers one word per 8 kHz sample frame and pulls an active-low end-of-conversion line low when the word is valid. The block synchronises that line, finds its falling edge and captures the parallel word. It then arms a run flag, and a bit tick divided down from the system clock shifts the word out one bit per tick. With the default divider that tick is about 80 kHz, so a 125 µs frame holds ten bit slots: eight carry data and the rest stay idle.

A word is sign-magnitude coded. Bit 7 is 1 for a positive sample and 0 for a negative one, and bits 6..0 hold the magnitude. Bits go out MSB first, so the sign bit leads every burst. The line uses plain unipolar NRZ: a 1 drives the output high for one whole bit period, and a 0 leaves it low. A one-cycle valid strobe marks the start of each bit, and a frame marker flags the first bit of each burst. A strobe that arrives while a burst is still running does not disturb that burst. The new word is dropped and a sticky overrun flag is raised.

Top module: `pcm_burst_serializer`

## Requirements
- R1: While the synchronous active-low reset is applied, and at the first sample after it is released, `ser_data`, `bit_valid`, `frame_start` and `overrun` are all 0.
- R2: A falling edge on `eoc_n`, seen through a two-flop synchroniser, captures `pcm_word`. Changes to `pcm_word` after the capture have no effect on the burst.
- R3: Each accepted word produces exactly 8 bits, MSB first. The first bit is the sign (1 = positive, 0 = negative) and the seven magnitude bits follow in order from bit 6 down to bit 0.
- R4: Consecutive `bit_valid` pulses within a burst are exactly `BIT_DIV` clock cycles apart. `bit_valid` is high for one cycle, and `ser_data` holds its level for the whole bit period.
- R5: `frame_start` is high together with the first `bit_valid` pulse of a burst and at no other time.
- R6: After the eighth bit, the next bit slot returns `ser_data` to 0. No `bit_valid` pulse follows until a new strobe is accepted.
- R7: A strobe that is detected while a burst is running sets `overrun`. The flag stays set until reset, the new word is discarded, and the running burst completes unchanged.
- R8: The first bit of a burst appears between 3 and `BIT_DIV`+5 clock cycles after `eoc_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eoc_n | input | 1 | Asynchronous active-low end-of-conversion strobe from the converter |
| pcm_word | input | PCM_W | Sign-magnitude sample word (MSB = sign, 1 means positive) |
| ser_data | output | 1 | Unipolar NRZ serial data, idles low |
| bit_valid | output | 1 | One-cycle pulse at the start of each data bit |
| frame_start | output | 1 | High with the first bit of each burst |
| overrun | output | 1 | Sticky flag: a strobe arrived while a burst was running |

## Verification
The assertions rely on three assumptions about the inputs and the parameters.
- `pcm_word` is stable from the fall of `eoc_n` until the synchronised edge has loaded it, which takes three clock cycles.
- `eoc_n` returns high between strobes for longer than the synchroniser depth.
- `BIT_DIV` is at least 2, so bit ticks never fall on adjacent cycles.

The stimulus holds each word for exactly three cycles after the strobe and then inverts it, which exercises the capture window at its edge. It keeps `eoc_n` high for many cycles between strobes. It uses a small divider of 12 so that bursts stay short.

// File: rtl/pcm_ser_pkg.sv
// Package: shared constants and the sample word layout for the PCM burst serializer.
// Assumes sign-magnitude words: the MSB is set for positive samples.
package pcm_ser_pkg;
    localparam int unsigned PCM_WORD_W = 8;

    typedef struct packed {
        logic                  positive;
        logic [PCM_WORD_W-2:0] magnitude;
    } pcm_sample_t;
endpackage

// File: rtl/pcm_eoc_sync.sv
// Module: pcm_eoc_sync
// Brings the asynchronous active-low end-of-conversion line into the clock
// domain through SYNC_STAGES flops, then emits a one-cycle pulse for each
// falling edge. Assumes the line stays high for more than SYNC_STAGES cycles
// between strobes.
module pcm_eoc_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc_n_async,
    output logic fall_pulse
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev_lvl;

    // Purpose: shift the raw line through the synchroniser chain; idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain[0] <= eoc_n_async;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    // Purpose: remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl <= 1'b1;
        end else begin
            prev_lvl <= chain[SYNC_STAGES-1];
        end
    end

    assign fall_pulse = prev_lvl & ~chain[SYNC_STAGES-1];

    // R2: an edge pulse never lasts two cycles.
    p_single_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |=> !fall_pulse)
        else $error("edge pulse held for two cycles");
endmodule

// File: rtl/pcm_bit_tick.sv
// Module: pcm_bit_tick
// Free-running divider: raises tick for one cycle every DIV system cycles.
// This tick sets the serial bit rate. Assumes DIV >= 2.
module pcm_bit_tick #(
    parameter int unsigned DIV = 1563
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

    logic [DIV_W-1:0] div_cnt;

    // Purpose: count system cycles and wrap at the end of each bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (div_cnt == LAST) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign tick = (div_cnt == LAST);

    generate
        if (DIV > 1) begin : g_tick_chk
            // R4: ticks are never adjacent, so each bit lasts more than one cycle.
            p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick)
                else $error("bit ticks on adjacent cycles");
        end
    endgenerate
endmodule

// File: rtl/pcm_shift_core.sv
// Module: pcm_shift_core
// Captures a word when a load request arrives while idle. While the run flag
// is set, each bit tick shifts one bit out MSB first. A bit counter clears the
// run flag after the last bit. A load request during a burst sets a sticky
// overrun and is dropped. Assumes load_req is a single-cycle pulse.
module pcm_shift_core #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_req,
    input  logic         tick,
    input  logic [W-1:0] word,
    output logic         ser_data,
    output logic         bit_valid,
    output logic         frame_start,
    output logic         overrun
);
    localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] bit_cnt;
    logic             running;
    logic             shift_en;

    assign shift_en = tick & running;

    // Purpose: run flag and bit counter; load arms the flag, the last bit clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            bit_cnt <= '0;
        end else if (load_req && !running) begin
            running <= 1'b1;
            bit_cnt <= '0;
        end else if (shift_en) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
                running <= 1'b0;
            end
        end
    end

    // Purpose: word register; capture when idle, shift left on each bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load_req && !running) begin
            shreg <= word;
        end else if (shift_en) begin
            shreg <= {shreg[W-2:0], 1'b0};
        end
    end

    // Purpose: line drivers; present a bit per tick, return the line low on idle ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_data    <= 1'b0;
            bit_valid   <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            bit_valid   <= shift_en;
            frame_start <= shift_en && (bit_cnt == '0);
            if (shift_en) begin
                ser_data <= shreg[W-1];
            end else if (tick) begin
                ser_data <= 1'b0;
            end
        end
    end

    // Purpose: sticky overrun when a strobe arrives while a burst is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (load_req && running) begin
            overrun <= 1'b1;
        end
    end

    // R5: the frame marker only ever accompanies a bit strobe.
    p_frame_with_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> bit_valid)
        else $error("frame marker without a bit");

    // R7: overrun stays set once raised.
    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun)
        else $error("overrun cleared without reset");

    // R7: a running burst is never reloaded; the word only moves on ticks.
    p_burst_intact_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick) |=> $stable(shreg))
        else $error("shift register changed mid-burst without a tick");

    // R3: the run flag drops only on the cycle that sends the last bit.
    p_end_on_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> bit_valid)
        else $error("burst ended without a final bit");

    // R6: bits are only emitted while the run flag is set.
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(running))
        else $error("bit strobe while idle");
endmodule

// File: rtl/pcm_burst_serializer.sv
// Module: pcm_burst_serializer (top)
// Serialises one PCM word per end-of-conversion strobe as a burst of PCM_W
// unipolar NRZ bits, MSB first, paced by a divided bit tick. Assumes pcm_word
// is stable for SYNC_STAGES+1 cycles after eoc_n falls and BIT_DIV >= 2.
module pcm_burst_serializer #(
    parameter int unsigned PCM_W       = pcm_ser_pkg::PCM_WORD_W,
    parameter int unsigned BIT_DIV     = 1563,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoc_n,
    input  logic [PCM_W-1:0] pcm_word,
    output logic             ser_data,
    output logic             bit_valid,
    output logic             frame_start,
    output logic             overrun
);
    logic eoc_fall;
    logic bit_tick;

    pcm_eoc_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .eoc_n_async (eoc_n),
        .fall_pulse  (eoc_fall)
    );

    pcm_bit_tick #(.DIV(BIT_DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bit_tick)
    );

    pcm_shift_core #(.W(PCM_W)) core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_req    (eoc_fall),
        .tick        (bit_tick),
        .word        (pcm_word),
        .ser_data    (ser_data),
        .bit_valid   (bit_valid),
        .frame_start (frame_start),
        .overrun     (overrun)
    );
endmodule

// File: tb/pcm_burst_serializer_tb.sv
`timescale 1ns/1ps
module pcm_burst_serializer_tb_top;
    localparam int DIV = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eoc_n = 1'b1;
    logic [7:0] pcm_word = 8'h00;
    logic       ser_data, bit_valid, frame_start, overrun;

    int n_checks = 0;
    int n_err    = 0;

    // monitor state
    int         cyc = 0;
    int         bit_cnt = 0;
    logic [7:0] rx = 8'h00;
    int         last_bv = 0;
    int         first_bv = 0;
    int         gap_bad = 0;
    int         fs_bad = 0;
    int         hold_bad = 0;
    logic       prev_ser = 1'b0;

    always #4 clk = ~clk;

    pcm_burst_serializer #(.BIT_DIV(DIV)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .eoc_n       (eoc_n),
        .pcm_word    (pcm_word),
        .ser_data    (ser_data),
        .bit_valid   (bit_valid),
        .frame_start (frame_start),
        .overrun     (overrun)
    );

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (bit_valid) begin
                if (bit_cnt == 0) first_bv = cyc;
                else if (cyc - last_bv != DIV) gap_bad++;
                if (frame_start != (bit_cnt == 0)) fs_bad++;
                rx = {rx[6:0], ser_data};
                bit_cnt++;
                last_bv = cyc;
            end else begin
                if (frame_start) fs_bad++;
                if (bit_cnt > 0 && bit_cnt < 8 && ser_data != prev_ser) hold_bad++;
            end
            prev_ser = ser_data;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_monitor();
        bit_cnt = 0; gap_bad = 0; fs_bad = 0; hold_bad = 0; rx = 8'h00;
    endtask

    // Strobe one word; scramble the word once it has been captured (R2).
    task automatic strobe(input logic [7:0] w, output int t0);
        @(negedge clk);
        pcm_word = w;
        eoc_n    = 1'b0;
        t0       = cyc;
        repeat (3) @(negedge clk);
        pcm_word = ~w;
        eoc_n    = 1'b1;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(ser_data == 0,    "R1", "ser_data in reset",    ser_data, 0);
        check(bit_valid == 0,   "R1", "bit_valid in reset",   bit_valid, 0);
        check(frame_start == 0, "R1", "frame_start in reset", frame_start, 0);
        check(overrun == 0,     "R1", "overrun in reset",     overrun, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ser_data == 0 && bit_valid == 0 && overrun == 0, "R1",
              "outputs after release", {ser_data, bit_valid, overrun}, 0);
    endtask

    task automatic test_burst(input logic [7:0] w);
        int t0;
        clear_monitor();
        strobe(w, t0);
        repeat (DIV * 11) @(negedge clk);
        check(bit_cnt == 8,   "R3", "bit count",           bit_cnt, 8);
        check(rx == w,        "R3", "serial word MSB first", rx, w);
        check(rx[7] == w[7],  "R3", "sign bit leads",      rx[7], w[7]);
        check(rx != ~w,       "R2", "post-capture change ignored", rx, w);
        check(gap_bad == 0,   "R4", "bit spacing errors",  gap_bad, 0);
        check(hold_bad == 0,  "R4", "level hold errors",   hold_bad, 0);
        check(fs_bad == 0,    "R5", "frame marker errors", fs_bad, 0);
        check(ser_data == 0,  "R6", "line idle after burst", ser_data, 0);
        check(first_bv - t0 >= 3 && first_bv - t0 <= DIV + 5, "R8",
              "first bit latency", first_bv - t0, DIV);
        repeat (DIV * 3) @(negedge clk);
        check(bit_cnt == 8,   "R6", "no bits while idle",  bit_cnt, 8);
    endtask

    task automatic test_overrun();
        int t0, t1;
        clear_monitor();
        strobe(8'hC3, t0);
        repeat (DIV * 3) @(negedge clk);
        strobe(8'h1E, t1);
        repeat (4) @(negedge clk);
        check(overrun == 1,   "R7", "overrun raised",      overrun, 1);
        repeat (DIV * 10) @(negedge clk);
        check(rx == 8'hC3,    "R7", "running burst intact", rx, 8'hC3);
        check(bit_cnt == 8,   "R7", "dropped word not sent", bit_cnt, 8);
        check(gap_bad == 0 && fs_bad == 0, "R7", "burst timing kept", gap_bad + fs_bad, 0);
        test_burst(8'h24);
        check(overrun == 1,   "R7", "overrun sticky",      overrun, 1);
    endtask

    initial begin
        #(8 * 150000);
        $display("FAIL watchdog: run did not complete: actual 0 expected 1");
        n_err++;
        n_checks++;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        test_reset();
        repeat (DIV * 2) @(negedge clk);
        test_burst(8'h86);   // positive sample, magnitude 6
        test_burst(8'h24);   // negative sample, magnitude 36
        test_burst(8'hFF);   // full-scale positive
        test_burst(8'h00);   // all-zero word: pulses but no high level
        test_burst(8'hA5);
        test_overrun();
        test_reset();
        check(overrun == 0, "R1", "reset clears overrun", overrun, 0);
        test_burst(8'h7F);   // full-scale negative
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule